// File: doc/BRIEF.md
# Streaming Sobel Edge Magnitude Filter

This block computes an edge-strength image from a raster-ordered stream of grey pixels. Each accepted pixel enters a sliding 3x3 neighbourhood built from a shift chain two rows plus three pixels deep. For every position the block emits the sum of the absolute horizontal and vertical Sobel gradients, clipped to the pixel range. Positions on the outer ring of the image have no full neighbourhood, so the block writes zero there.

Both sides use a valid/ready handshake. A per-frame iteration counter steps through three phases. In the first W+1 iterations the block only primes the window. In the middle phase it takes one pixel and produces one result per iteration. In the last W+1 iterations it shifts zeros in without reading the input, so that the final results drain. Then the counters wrap for the next frame. A short fixed-depth arithmetic pipeline follows the window, and every stage moves only when the stage after it can accept data.

Top module: `sobel_stream_top`

## Requirements
- R1: A pixel transfers on a side only in a cycle where that side's valid and ready are both high. While out_valid is high and out_ready is low, out_valid stays high and out_data holds its value.
- R2: When in_valid and out_ready stay high, a frame's H*W input pixels are taken on consecutive cycles, and its H*W results leave on consecutive cycles.
- R3: The first W+1 pixels of a frame produce no result. With only those accepted, out_valid stays low.
- R4: After the last pixel of a frame is taken, in_ready stays low for exactly W+1 iterations while zeros are shifted in. The last results of the frame still come out with no further input.
- R5: For an interior position (row r, column c), the result is min(255, |Gx| + |Gy|). Here Gx is (right column, weighted 1,2,1 top to bottom) minus (left column, same weights), and Gy is (bottom row, weighted 1,2,1 left to right) minus (top row, same weights).
- R6: Positions in row 0, row H-1, column 0 or column W-1 produce the value 0.
- R7: Each frame yields exactly H*W results in raster order. After the last flush iteration the counters return to zero and the next frame starts at row 0, column 0.
- R8: When the arithmetic pipeline cannot advance, in_ready is low. No result is lost or duplicated under backpressure.
- R9: Gaps in in_valid stall the block without changing any result.
- R10: During and after reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | PIX_W | Incoming pixel, raster order |
| in_valid | input | 1 | Incoming pixel present |
| in_ready | output | 1 | Block takes a pixel this cycle |
| out_data | output | PIX_W | Edge magnitude result |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream accepts the result |

## Verification
The assertions check four things on every cycle. A stalled result is held stable. No input is taken during the flush phase. No input is taken when the pipeline head cannot advance. Any result at a ring position is zero, with the position tracked from the output handshakes alone. The bench scenarios show what spans whole frames. These are the gradient values and saturation against a bench model, the silence of the fill phase, and the exact W+1-cycle flush gap at full rate. They also cover back-to-back frames with wrapping counters, and the fact that random input gaps and output stalls leave every result unchanged.

// File: rtl/sobel_pkg.sv
package sobel_pkg;
  typedef enum logic [1:0] {
    PH_FILL  = 2'd0,
    PH_RUN   = 2'd1,
    PH_FLUSH = 2'd2
  } phase_e;
endpackage

// File: rtl/sobel_iter_ctrl.sv
module sobel_iter_ctrl
  import sobel_pkg::*;
#(
  parameter int IMG_W = 512,
  parameter int IMG_H = 512
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   adv,
  input  logic   in_valid,
  output logic   in_ready,
  output logic   fire,
  output logic   emit,
  output logic   border,
  output phase_e phase
);
  localparam int FILL_N = IMG_W + 1;
  localparam int PIX_N  = IMG_W * IMG_H;
  localparam int ITER_N = PIX_N + FILL_N;
  localparam int IT_W   = $clog2(ITER_N);
  localparam int COL_W  = $clog2(IMG_W);
  localparam int ROW_W  = $clog2(IMG_H);

  logic [IT_W-1:0]  it_q, it_d;
  logic [COL_W-1:0] col_q, col_d;
  logic [ROW_W-1:0] row_q, row_d;
  phase_e           ph_q, ph_d;

  // one iteration per enabled cycle; flush iterations need no input
  assign fire     = adv && ((ph_q == PH_FLUSH) || in_valid);
  assign in_ready = adv && (ph_q != PH_FLUSH);
  assign emit     = (ph_q != PH_FILL);
  assign border   = (row_q == '0) || (row_q == ROW_W'(IMG_H - 1)) ||
                    (col_q == '0) || (col_q == COL_W'(IMG_W - 1));
  assign phase    = ph_q;

  always_comb begin
    it_d  = it_q;
    col_d = col_q;
    row_d = row_q;
    ph_d  = ph_q;
    if (fire) begin
      if (it_q == IT_W'(ITER_N - 1)) begin
        it_d  = '0;
        col_d = '0;
        row_d = '0;
        ph_d  = PH_FILL;
      end else begin
        it_d = it_q + 1'b1;
        if (it_q == IT_W'(FILL_N - 1)) ph_d = PH_RUN;
        if (it_q == IT_W'(PIX_N - 1))  ph_d = PH_FLUSH;
        if (emit) begin
          if (col_q == COL_W'(IMG_W - 1)) begin
            col_d = '0;
            row_d = row_q + 1'b1;
          end else begin
            col_d = col_q + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      it_q  <= '0;
      col_q <= '0;
      row_q <= '0;
      ph_q  <= PH_FILL;
    end else begin
      it_q  <= it_d;
      col_q <= col_d;
      row_q <= row_d;
      ph_q  <= ph_d;
    end
  end
endmodule

// File: rtl/sobel_line_window.sv
module sobel_line_window #(
  parameter int IMG_W = 512,
  parameter int PIX_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift,
  input  logic [PIX_W-1:0]   din,
  output logic [9*PIX_W-1:0] taps
);
  localparam int DEPTH = 2 * IMG_W + 3;

  logic [PIX_W-1:0] chain_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) chain_q[k] <= '0;
    end else if (shift) begin
      chain_q[0] <= din;
      for (int k = 1; k < DEPTH; k++) chain_q[k] <= chain_q[k-1];
    end
  end

  // tap index = row*3 + col, row 0 = top, col 0 = left
  for (genvar r = 0; r < 3; r++) begin : g_row
    for (genvar c = 0; c < 3; c++) begin : g_col
      assign taps[(r*3+c)*PIX_W +: PIX_W] = chain_q[(2-r)*IMG_W + (2-c)];
    end
  end
endmodule

// File: rtl/sobel_grad_pipe.sv
module sobel_grad_pipe #(
  parameter int PIX_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               border_in,
  input  logic [9*PIX_W-1:0] taps,
  input  logic               out_ready,
  output logic               adv0,
  output logic               out_valid,
  output logic [PIX_W-1:0]   out_data
);
  localparam int SW = PIX_W + 2;
  localparam int TW = SW + 1;
  localparam logic [TW-1:0] MAXV = TW'((1 << PIX_W) - 1);

  logic          v0_q, v0_d, b0_q, b0_d;
  logic          v1_q, v1_d, b1_q, b1_d;
  logic [SW-1:0] ax_q, ax_d, ay_q, ay_d;
  logic          v2_q, v2_d;
  logic [PIX_W-1:0] r2_q, r2_d;
  logic          en1, en2;

  function automatic logic [SW-1:0] wsum(input logic [PIX_W-1:0] a,
                                         input logic [PIX_W-1:0] b,
                                         input logic [PIX_W-1:0] c);
    return SW'(a) + (SW'(b) << 1) + SW'(c);
  endfunction

  function automatic logic [SW-1:0] adiff(input logic [SW-1:0] p,
                                          input logic [SW-1:0] n);
    return (p >= n) ? (p - n) : (n - p);
  endfunction

  function automatic logic [PIX_W-1:0] px(input logic [9*PIX_W-1:0] t,
                                          input int idx);
    return t[idx*PIX_W +: PIX_W];
  endfunction

  logic [SW-1:0] gx_pos, gx_neg, gy_pos, gy_neg;
  logic [TW-1:0] mag;

  assign gx_pos = wsum(px(taps, 2), px(taps, 5), px(taps, 8));
  assign gx_neg = wsum(px(taps, 0), px(taps, 3), px(taps, 6));
  assign gy_pos = wsum(px(taps, 6), px(taps, 7), px(taps, 8));
  assign gy_neg = wsum(px(taps, 0), px(taps, 1), px(taps, 2));
  assign mag    = TW'(ax_q) + TW'(ay_q);

  assign en2  = !v2_q || out_ready;
  assign en1  = !v1_q || en2;
  assign adv0 = !v0_q || en1;

  always_comb begin
    v0_d = v0_q;  b0_d = b0_q;
    v1_d = v1_q;  b1_d = b1_q;  ax_d = ax_q;  ay_d = ay_q;
    v2_d = v2_q;  r2_d = r2_q;
    if (adv0) begin
      v0_d = load;
      b0_d = border_in;
    end
    if (en1) begin
      v1_d = v0_q;
      b1_d = b0_q;
      ax_d = adiff(gx_pos, gx_neg);
      ay_d = adiff(gy_pos, gy_neg);
    end
    if (en2) begin
      v2_d = v1_q;
      if (b1_q)             r2_d = '0;
      else if (mag > MAXV)  r2_d = MAXV[PIX_W-1:0];
      else                  r2_d = mag[PIX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v0_q <= 1'b0;  b0_q <= 1'b0;
      v1_q <= 1'b0;  b1_q <= 1'b0;  ax_q <= '0;  ay_q <= '0;
      v2_q <= 1'b0;  r2_q <= '0;
    end else begin
      v0_q <= v0_d;  b0_q <= b0_d;
      v1_q <= v1_d;  b1_q <= b1_d;  ax_q <= ax_d;  ay_q <= ay_d;
      v2_q <= v2_d;  r2_q <= r2_d;
    end
  end

  assign out_valid = v2_q;
  assign out_data  = r2_q;
endmodule

// File: rtl/sobel_stream_top.sv
module sobel_stream_top
  import sobel_pkg::*;
#(
  parameter int IMG_W = 512,
  parameter int IMG_H = 512,
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [PIX_W-1:0] out_data,
  output logic             out_valid,
  input  logic             out_ready
);
  logic               grad_adv;
  logic               iter_fire;
  logic               iter_emit;
  logic               iter_border;
  phase_e             ctrl_phase;
  logic [PIX_W-1:0]   win_din;
  logic [9*PIX_W-1:0] win_taps;

  sobel_iter_ctrl #(.IMG_W(IMG_W), .IMG_H(IMG_H)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (grad_adv),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .fire     (iter_fire),
    .emit     (iter_emit),
    .border   (iter_border),
    .phase    (ctrl_phase)
  );

  assign win_din = (ctrl_phase == PH_FLUSH) ? '0 : in_data;

  sobel_line_window #(.IMG_W(IMG_W), .PIX_W(PIX_W)) win_i (
    .clk   (clk),
    .rst_n (rst_n),
    .shift (iter_fire),
    .din   (win_din),
    .taps  (win_taps)
  );

  sobel_grad_pipe #(.PIX_W(PIX_W)) grad_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (iter_fire && iter_emit),
    .border_in (iter_border),
    .taps      (win_taps),
    .out_ready (out_ready),
    .adv0      (grad_adv),
    .out_valid (out_valid),
    .out_data  (out_data)
  );
endmodule

// File: rtl/sobel_stream_chk.sv
module sobel_stream_chk
  import sobel_pkg::*;
#(
  parameter int IMG_W = 512,
  parameter int IMG_H = 512,
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIX_W-1:0] out_data,
  input phase_e           phase,
  input logic             grad_adv
);
  localparam int COL_W = $clog2(IMG_W);
  localparam int ROW_W = $clog2(IMG_H);

  logic [COL_W-1:0] ocol_q;
  logic [ROW_W-1:0] orow_q;

  // output position tracked purely from the output handshake
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ocol_q <= '0;
      orow_q <= '0;
    end else if (out_valid && out_ready) begin
      if (ocol_q == COL_W'(IMG_W - 1)) begin
        ocol_q <= '0;
        orow_q <= (orow_q == ROW_W'(IMG_H - 1)) ? '0 : orow_q + 1'b1;
      end else begin
        ocol_q <= ocol_q + 1'b1;
      end
    end
  end

  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r4_flush_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FLUSH) |-> !in_ready);

  a_r6_border_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (ocol_q == '0 || ocol_q == COL_W'(IMG_W - 1) ||
                   orow_q == '0 || orow_q == ROW_W'(IMG_H - 1)))
      |-> (out_data == '0));

  a_r8_full_block: assert property (@(posedge clk) disable iff (!rst_n)
    !grad_adv |-> !in_ready);
endmodule

bind sobel_stream_top sobel_stream_chk #(
  .IMG_W(IMG_W), .IMG_H(IMG_H), .PIX_W(PIX_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .phase     (ctrl_phase),
  .grad_adv  (grad_adv)
);

// File: tb/sobel_stream_top_tb.sv
`timescale 1ns/1ps
module sobel_stream_top_tb_top;
  localparam int W  = 6;
  localparam int H  = 5;
  localparam int HW = W * H;
  localparam int F  = W + 1;
  localparam int NF = 6;

  logic       clk;
  logic       rst_n;
  logic [7:0] in_data;
  logic       in_valid;
  logic       in_ready;
  logic [7:0] out_data;
  logic       out_valid;
  logic       out_ready;

  int nchk = 0;
  int nerr = 0;
  int img [NF*HW];
  int rx  [NF*HW];
  int run_mism;
  bit done = 0;

  sobel_stream_top #(.IMG_W(W), .IMG_H(H), .PIX_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input int got, input int exp, input string what);
    nchk++;
    if (got != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  function automatic int pxl(int f, int r, int c);
    return img[f*HW + r*W + c];
  endfunction

  function automatic int exp_px(int f, int p);
    int r = p / W;
    int c = p % W;
    int gx, gy, s;
    if (r == 0 || r == H-1 || c == 0 || c == W-1) return 0;
    gx = (pxl(f,r-1,c+1) + 2*pxl(f,r,c+1) + pxl(f,r+1,c+1))
       - (pxl(f,r-1,c-1) + 2*pxl(f,r,c-1) + pxl(f,r+1,c-1));
    gy = (pxl(f,r+1,c-1) + 2*pxl(f,r+1,c) + pxl(f,r+1,c+1))
       - (pxl(f,r-1,c-1) + 2*pxl(f,r-1,c) + pxl(f,r-1,c+1));
    s = (gx < 0 ? -gx : gx) + (gy < 0 ? -gy : gy);
    return (s > 255) ? 255 : s;
  endfunction

  function automatic bit on_ring(int p);
    int r = p / W;
    int c = p % W;
    return (r == 0 || r == H-1 || c == 0 || c == W-1);
  endfunction

  task automatic run(input int nfr, input int fb, input int pv, input int pr,
                     input int pause_at, input bit full);
    int total = nfr * HW;
    int ii = 0, oi = 0, cyc = 0;
    int first_i = -1, last_i = -1, first_o = -1, last_o = -1;
    int low_after = 0, outs_after = 0, pause_left = 20, pause_bad = 0;
    bit seen_high = 0, held = 0;
    int held_val = 0;
    run_mism = 0;
    while (oi < total && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (held) begin
        chk("R1", {31'd0, out_valid}, 1, "stalled valid held");
        chk("R1", int'(out_data), held_val, "stalled data held");
      end
      if (pause_at >= 0 && ii == pause_at && pause_left > 0) begin
        in_valid = 1'b0;
        pause_left--;
      end else begin
        in_valid = (ii < total) && ($urandom_range(99) < pv);
      end
      in_data   = in_valid ? 8'(img[fb*HW + ii]) : 8'h00;
      out_ready = ($urandom_range(99) < pr);
      #1;
      if (pause_at >= 0 && ii == pause_at && pause_left > 0 && out_valid) pause_bad++;
      if (full && last_i >= 0 && !seen_high) begin
        if (in_ready) seen_high = 1; else low_after++;
      end
      if (in_valid && in_ready) begin
        if (first_i < 0) first_i = cyc;
        ii++;
        if (ii == total) last_i = cyc;
      end
      held = out_valid && !out_ready;
      held_val = int'(out_data);
      if (out_valid && out_ready) begin
        int e = exp_px(fb + oi / HW, oi % HW);
        rx[oi] = int'(out_data);
        if (int'(out_data) != e) run_mism++;
        chk(on_ring(oi % HW) ? "R6" : "R5", int'(out_data), e, "result value");
        if (first_o < 0) first_o = cyc;
        last_o = cyc;
        if (last_i >= 0 && cyc > last_i) outs_after++;
        oi++;
      end
    end
    chk("R7", oi, total, "results per run");
    chk("R8", ii, total, "inputs taken under backpressure");
    if (pause_at >= 0) chk("R3", pause_bad, 0, "results during fill pause");
    if (full) begin
      chk("R2", last_i - first_i, HW - 1, "input span at full rate");
      chk("R2", last_o - first_o, HW - 1, "output span at full rate");
      chk("R4", low_after, F, "in_ready low cycles in flush");
      chk("R4", outs_after, F + 3, "results after last input");
    end else begin
      chk("R4", int'(outs_after >= F), 1, "results drained after last input");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240917));
    for (int f = 0; f < NF; f++) begin
      for (int p = 0; p < HW; p++) begin
        if (f == 5) img[f*HW + p] = ((p % W) >= W/2) ? 255 : 0;
        else        img[f*HW + p] = $urandom_range(255);
      end
    end
    rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R10", {31'd0, out_valid}, 0, "out_valid in reset");
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R10", {31'd0, out_valid}, 0, "out_valid after reset");
    chk("R10", {31'd0, in_ready}, 1, "in_ready after reset");

    run(1, 0, 100, 100, -1, 1'b1);
    run(1, 1, 100, 100, F, 1'b0);
    chk("R9", run_mism, 0, "mismatches with input gap");
    run(3, 2, 60, 50, -1, 1'b0);
    chk("R9", run_mism, 0, "mismatches with random gaps");
    run(1, 5, 100, 35, -1, 1'b0);
    chk("R5", rx[1*W + W/2], 255, "saturated step edge");

    in_valid = 1'b0;
    out_ready = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      #1;
      chk("R7", {31'd0, out_valid}, 0, "no extra result after frames");
    end
    chk("R7", {31'd0, in_ready}, 1, "ready for next frame");

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule